// File: doc/BRIEF.md
# One-wire bus bit-level master

This block drives a single open-drain one-wire data line under software control, one bit at a time. Software writes a divider value so that an internal time base ticks once per microsecond. It then writes one command bit into a 16-bit control word to start one of three operations:

- a bus reset followed by a presence-detect window;
- a write-0 slot;
- a write-1 slot, which is also the read slot.

The command bit stays set while the operation runs and clears itself when it finishes. Software polls the control word to see completion. It then reads back the presence flag or the sampled line level from the same word.

The line is driven only by pulling it low, through the output-enable `bus_oe`. The line level returns through `bus_in`, which passes a two-flop synchronizer before it is sampled. All timing is counted in ticks of the time base. The divider restarts at the start of every command, so each phase lasts an exact multiple of N input clocks. The divider register holds N-1.

The sequencer has four states:

- ST_IDLE: nothing runs.
- ST_RST_LOW: the line is held low for the reset pulse.
- ST_RST_WAIT: the line is released while presence is sampled.
- ST_SLOT: a write-0 or write-1/read slot runs.

Its transitions are:

- ST_IDLE to ST_RST_LOW on an accepted reset command.
- ST_IDLE to ST_SLOT on an accepted write-0 or write-1 command.
- ST_RST_LOW to ST_RST_WAIT when the 480th tick is reached.
- ST_RST_WAIT to ST_IDLE when the 480th tick after release is reached.
- ST_SLOT to ST_IDLE when the 70th tick is reached.

Top module: `owire_master`

## Requirements
- R1: After reset the control word reads 0, the divider register reads its reset value 49, and `bus_oe` is 0.
- R2: A write with `reg_addr`=1 stores the divider value D, which reads back at `reg_addr`=1. Every command phase then lasts a whole number of ticks of N=D+1 input clocks each.
- R3: Writing control bit 7 (with `reg_addr`=0) starts a reset. Take the clock edge that accepts the write as the reference. `bus_oe` is 1 for the first 480·N cycles after that edge and 0 afterwards. Bit 7 reads 1 for 960·N cycles and 0 from then on.
- R4: Control bit 6 is the presence flag. It is updated on the 70th tick after the line is released during a reset. It becomes 1 if the synchronized line is low then, and 0 if it is high.
- R5: Writing control bit 5 starts a write-0 slot. `bus_oe` is 1 for 60·N cycles, and bit 5 reads 1 for 70·N cycles.
- R6: Writing control bit 4 starts a write-1/read slot. `bus_oe` is 1 for 6·N cycles, and bit 4 reads 1 for 70·N cycles. Control bit 3 takes the synchronized line level on the 15th tick of the slot.
- R7: While any of control bits 7, 5 or 4 is set, writes to the control word are ignored. The running command keeps its timing, and no other command starts.
- R8: If one control write sets several command bits, exactly one command starts, chosen in the priority bit 7, then bit 5, then bit 4.
- R9: Bit 3 is changed only by a write-1/read slot, and bit 6 only by a reset. Both hold their values across other commands and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register select: 0 control word, 1 divider |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| bus_oe | output | 1 | High pulls the one-wire line low |
| bus_in | input | 1 | Line level, asynchronous |

## Verification
Every result is timed from the clock edge that accepts the control write:

- `bus_oe` and the command bit change on that same edge.
- For a reset, `bus_oe` falls exactly 480·N edges later and the command bit clears 960·N edges later.
- For a write-0, `bus_oe` falls 60·N edges later; for a write-1/read, 6·N edges later. Both slots clear the command bit 70·N edges later.

The bench drives inputs and samples outputs on the falling edge. It counts the falling edges at which `bus_oe` and the command bit are high, so each count must equal the tick count times N exactly. The presence and read flags are checked once the command bit has cleared. The slave holds the line steady through the whole command, which removes the two-cycle synchronizer delay from the result.

// File: rtl/owire_pkg.sv
package owire_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_SLOT
    } ow_state_t;

    localparam int BIT_RST  = 7;
    localparam int BIT_PRES = 6;
    localparam int BIT_W0   = 5;
    localparam int BIT_W1   = 4;
    localparam int BIT_RD   = 3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/owire_tick_gen.sv
module owire_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/owire_sync.sv
module owire_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b1;
            sync_out <= 1'b1;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/owire_seq.sv
module owire_seq
    import owire_pkg::*;
#(
    parameter int RST_LOW  = 480,
    parameter int RST_REL  = 480,
    parameter int PRES_AT  = 70,
    parameter int W0_LOW   = 60,
    parameter int W1_LOW   = 6,
    parameter int RD_AT    = 15,
    parameter int SLOT_LEN = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rst,
    input  logic start_w0,
    input  logic start_w1,
    input  logic tick,
    input  logic line,
    output logic bus_oe,
    output logic done,
    output logic pres_upd,
    output logic rd_upd
);
    localparam int CNT_W = $clog2(max3(RST_LOW, RST_REL, SLOT_LEN) + 1);

    ow_state_t        state_q, state_d;
    logic [CNT_W-1:0] tcnt_q;
    logic             w1_q;
    logic [CNT_W-1:0] low_lim;
    logic             unused_line;

    assign unused_line = line;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_rst)                 state_d = ST_RST_LOW;
                else if (start_w0 || start_w1) state_d = ST_SLOT;
            end
            ST_RST_LOW: begin
                if (tick && tcnt_q == CNT_W'(RST_LOW - 1))  state_d = ST_RST_WAIT;
            end
            ST_RST_WAIT: begin
                if (tick && tcnt_q == CNT_W'(RST_REL - 1))  state_d = ST_IDLE;
            end
            ST_SLOT: begin
                if (tick && tcnt_q == CNT_W'(SLOT_LEN - 1)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Tick counter and slot kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            w1_q   <= 1'b0;
        end else begin
            if (state_q != state_d) begin
                tcnt_q <= '0;
            end else if (tick && state_q != ST_IDLE) begin
                tcnt_q <= tcnt_q + 1'b1;
            end
            if (state_q == ST_IDLE && !start_rst && (start_w0 || start_w1)) begin
                w1_q <= !start_w0;
            end
        end
    end

    assign low_lim = w1_q ? CNT_W'(W1_LOW) : CNT_W'(W0_LOW);

    // Outputs
    always_comb begin
        bus_oe   = 1'b0;
        pres_upd = 1'b0;
        rd_upd   = 1'b0;
        unique case (state_q)
            ST_IDLE:     bus_oe = 1'b0;
            ST_RST_LOW:  bus_oe = 1'b1;
            ST_RST_WAIT: pres_upd = tick && (tcnt_q == CNT_W'(PRES_AT - 1));
            ST_SLOT: begin
                bus_oe = (tcnt_q < low_lim);
                rd_upd = w1_q && tick && (tcnt_q == CNT_W'(RD_AT - 1));
            end
            default: bus_oe = 1'b0;
        endcase
        done = (state_q != ST_IDLE) && (state_d == ST_IDLE);
    end
endmodule

// File: rtl/owire_master.sv
module owire_master
    import owire_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int DIV_RESET = 49
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             bus_oe,
    input  logic             bus_in
);
    logic [REG_W-1:0] div_q;
    logic cmd_rst, cmd_w0, cmd_w1, pres_q, rdbit_q;
    logic busy, accept, start_rst, start_w0, start_w1;
    logic tick, line, done, pres_upd, rd_upd;

    assign busy      = cmd_rst || cmd_w0 || cmd_w1;
    assign accept    = reg_wr && !reg_addr && !busy;
    assign start_rst = accept && reg_wdata[BIT_RST];
    assign start_w0  = accept && !reg_wdata[BIT_RST] && reg_wdata[BIT_W0];
    assign start_w1  = accept && !reg_wdata[BIT_RST] && !reg_wdata[BIT_W0] && reg_wdata[BIT_W1];

    owire_tick_gen #(.DIV_W(REG_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_rst || start_w0 || start_w1),
        .div_val (div_q),
        .tick    (tick)
    );

    owire_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_in),
        .sync_out (line)
    );

    owire_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rst (start_rst),
        .start_w0  (start_w0),
        .start_w1  (start_w1),
        .tick      (tick),
        .line      (line),
        .bus_oe    (bus_oe),
        .done      (done),
        .pres_upd  (pres_upd),
        .rd_upd    (rd_upd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= REG_W'(DIV_RESET);
            cmd_rst <= 1'b0;
            cmd_w0  <= 1'b0;
            cmd_w1  <= 1'b0;
            pres_q  <= 1'b0;
            rdbit_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr) div_q <= reg_wdata;
            if (done) begin
                cmd_rst <= 1'b0;
                cmd_w0  <= 1'b0;
                cmd_w1  <= 1'b0;
            end else begin
                if (start_rst) cmd_rst <= 1'b1;
                if (start_w0)  cmd_w0  <= 1'b1;
                if (start_w1)  cmd_w1  <= 1'b1;
            end
            if (pres_upd) pres_q  <= !line;
            if (rd_upd)   rdbit_q <= line;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata = div_q;
        end else begin
            reg_rdata[BIT_RST]  = cmd_rst;
            reg_rdata[BIT_PRES] = pres_q;
            reg_rdata[BIT_W0]   = cmd_w0;
            reg_rdata[BIT_W1]   = cmd_w1;
            reg_rdata[BIT_RD]   = rdbit_q;
        end
    end
endmodule

// File: rtl/owire_master_chk.sv
module owire_master_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic reg_addr,
    input logic bus_oe,
    input logic cmd_rst,
    input logic cmd_w0,
    input logic cmd_w1,
    input logic rdbit_q
);
    logic busy;
    assign busy = cmd_rst || cmd_w0 || cmd_w1;

    // R8
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_rst, cmd_w0, cmd_w1}));

    // R7
    ignore_busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && !reg_addr) |=> (!$rose(cmd_rst) && !$rose(cmd_w0) && !$rose(cmd_w1)));

    // R5
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_oe);

    // R3
    rst_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_rst) |-> bus_oe);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!busy) |-> $stable(rdbit_q));
endmodule

bind owire_master owire_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .bus_oe   (bus_oe),
    .cmd_rst  (cmd_rst),
    .cmd_w0   (cmd_w0),
    .cmd_w1   (cmd_w1),
    .rdbit_q  (rdbit_q)
);

// File: tb/tb_owire_master.sv
`timescale 1ns/1ps
module tb_owire_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_oe;
    logic        bus_in;
    logic        slave_pull = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign bus_in = !(bus_oe || slave_pull);

    owire_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bus_oe    (bus_oe),
        .bus_in    (bus_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 1'b0;
    endtask

    task automatic measure(output int low, output int bcnt);
        int guard = 0;
        low  = 0;
        bcnt = 0;
        while ((reg_rdata[7] || reg_rdata[5] || reg_rdata[4]) && guard < 20000) begin
            bcnt++;
            if (bus_oe) low++;
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int low, bcnt, exp_rd, exp_pres, pre, pl;
        exp_rd = 0;
        exp_pres = 0;
        #35 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 16'h0000, "R1 ctrl", reg_rdata, 0);
        chk(bus_oe == 1'b0, "R1 oe", bus_oe, 0);
        reg_addr = 1'b1;
        #1;
        chk(reg_rdata == 16'd49, "R1 div", reg_rdata, 49);
        reg_addr = 1'b0;

        for (int n = 1; n <= 4; n++) begin
            wr(1'b1, 16'(n - 1));
            reg_addr = 1'b1;
            #1;
            chk(reg_rdata == 16'(n - 1), "R2 div readback", reg_rdata, n - 1);
            reg_addr = 1'b0;
            #1;
            for (int p = 0; p <= 1; p++) begin
                slave_pull = p[0];
                // R3 reset timing, R4 presence
                wr(1'b0, 16'h0080);
                measure(low, bcnt);
                chk(low == 480 * n, "R3 reset low", low, 480 * n);
                chk(bcnt == 960 * n, "R3 reset busy", bcnt, 960 * n);
                exp_pres = p;
                chk(reg_rdata[6] == exp_pres[0], "R4 presence", reg_rdata[6], exp_pres);
                chk(reg_rdata[3] == exp_rd[0], "R9 rd kept on reset", reg_rdata[3], exp_rd);
                // R5 write-0
                wr(1'b0, 16'h0020);
                measure(low, bcnt);
                chk(low == 60 * n, "R5 w0 low", low, 60 * n);
                chk(bcnt == 70 * n, "R5 w0 busy", bcnt, 70 * n);
                chk(reg_rdata[3] == exp_rd[0], "R9 rd kept on w0", reg_rdata[3], exp_rd);
                chk(reg_rdata[6] == exp_pres[0], "R9 pres kept on w0", reg_rdata[6], exp_pres);
                // R6 write-1/read
                wr(1'b0, 16'h0010);
                measure(low, bcnt);
                chk(low == 6 * n, "R6 w1 low", low, 6 * n);
                chk(bcnt == 70 * n, "R6 w1 busy", bcnt, 70 * n);
                exp_rd = 1 - p;
                chk(reg_rdata[3] == exp_rd[0], "R6 read bit", reg_rdata[3], exp_rd);
                chk(reg_rdata[6] == exp_pres[0], "R9 pres kept on w1", reg_rdata[6], exp_pres);
                chk(bus_oe == 1'b0, "R5 oe released", bus_oe, 0);
            end
        end

        // R7 control write during a running write-0 slot, N=2
        wr(1'b1, 16'd1);
        slave_pull = 1'b0;
        wr(1'b0, 16'h0020);
        pre = 0;
        pl = 0;
        for (int i = 0; i < 20; i++) begin
            if (reg_rdata[5]) pre++;
            if (bus_oe) pl++;
            @(negedge clk);
        end
        wr(1'b0, 16'h0080);
        chk(reg_rdata[7] == 1'b0 && reg_rdata[5] == 1'b1, "R7 cmd bits", reg_rdata[7:4], 2);
        measure(low, bcnt);
        chk(pre + 2 + bcnt == 140, "R7 busy kept", pre + 2 + bcnt, 140);
        chk(pl + 2 + low == 120, "R7 low kept", pl + 2 + low, 120);
        repeat (10) @(negedge clk);
        chk(reg_rdata == {8'h00, 1'b0, exp_pres[0], 2'b00, exp_rd[0], 3'b000},
            "R7 no late start", reg_rdata, 0);

        // R8 priority with several command bits, N=1
        wr(1'b1, 16'd0);
        wr(1'b0, 16'h0030);
        chk(reg_rdata[5:4] == 2'b10, "R8 w0 over w1", reg_rdata[5:4], 2);
        measure(low, bcnt);
        chk(low == 60 && bcnt == 70, "R8 w0 timing", low, 60);
        wr(1'b0, 16'h00B0);
        chk(reg_rdata[7:4] == 4'b1000 || reg_rdata[7:4] == 4'b1100, "R8 reset wins",
            reg_rdata[7:4], 8);
        measure(low, bcnt);
        chk(low == 480 && bcnt == 960, "R8 reset timing", low, 480);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule